// File: doc/BRIEF.md
# Sticky Per-Word Fuse Lock Bitmaps

This block holds the lock state that guards individual words of a fuse array. It keeps three independent bitmaps, one bit per word: a reload lock, a shadow-write lock and a program lock. Each bitmap is split into 32-bit bank registers, one per group of 32 words. Word `n` lives in bank `n >> 5` at bit `n & 31`. A small global lock register sits beside them. One bit freezes the upper fuse area, one freezes the debug configuration, and one freezes all programming.

Software sets lock bits through a simple register write port. Writes can only set bits, and only reset clears them. The fuse controller places a word index on the query port. It receives three combinational grants: refresh the shadow copy from the fuse, accept a software write to the shadow copy, or burn the fuse. A read-only bank view reports which words the fuse array already marks as permanently locked. That view also withdraws the program grant.

Top module: `fuse_word_lock`

## Requirements
- R1: After reset every bitmap bank and the global lock register read 0, and every in-range word index with no permanent lock receives all three grants.
- R2: A write to bank `b` of a bitmap ORs the write data into that bank. The program lock banks start at byte offset 0x064, the shadow-write lock banks at 0x07C and the reload lock banks at 0x094, with bank `b` at base + 4*b. A read of the same offset returns the bank.
- R3: Writing 0 to a lock bit leaves it unchanged, so no bit set since reset ever clears.
- R4: For word `n`, bit `n & 31` of bank `n >> 5` withdraws only its own grant: reload lock clears `reload_ok`, shadow-write lock clears `swrite_ok`, program lock clears `prog_ok`.
- R5: A word whose `perm_locked_i` bit is 1 never receives `prog_ok`, and its other grants are unaffected.
- R6: The global lock register at offset 0x010 is write-one-to-set on bits 0, 2 and 3 only. Every other bit reads 0. Bit 3 withdraws `prog_ok` for every word, and bit 2 drives `debug_cfg_locked`.
- R7: While global bit 0 is set, every word index at or above `UPPER_START` loses all three grants.
- R8: A word index at or above `NUM_BANKS*32` receives no grant.
- R9: Offset 0x04C + 4*b reads bank `b` of `perm_locked_i`, and writes to it have no effect.
- R10: A write to any other offset changes no register, and reads of other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; the only way to clear lock bits |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 12 | Byte offset of the write |
| reg_wdata | input | 32 | Write data; ones set lock bits |
| reg_raddr | input | 12 | Byte offset of the combinational read |
| reg_rdata | output | 32 | Read data for `reg_raddr` |
| perm_locked_i | input | NUM_BANKS*32 | Per-word permanent lock flags from the fuse array |
| chk_idx | input | IDXW | Word index being queried (IDXW = clog2(NUM_BANKS*32)+1) |
| reload_ok | output | 1 | Shadow refresh of `chk_idx` permitted |
| swrite_ok | output | 1 | Software write to the shadow of `chk_idx` permitted |
| prog_ok | output | 1 | Fuse program of `chk_idx` permitted |
| debug_cfg_locked | output | 1 | Debug configuration frozen |

## Verification
A wrong bit in a bitmap bank shows up in the read data of its offset on the first cycle after the write that caused it. It also shows up as a wrong grant, with no delay, whenever the query port holds the affected word. A bank or bit mis-mapping shows as a grant withdrawn for the wrong word, so each state of the bitmaps is followed by a sweep of every representable index, including out-of-range ones. Clearing, mis-masked global bits and writes that leak into read-only or unmapped offsets show in a full read-back of the register map after each step.

// File: rtl/fuse_lock_pkg.sv
package fuse_lock_pkg;
    localparam int            BANK_BITS   = 32;
    localparam int            ADDR_W      = 12;
    localparam logic [11:0]   OFF_GLOBAL  = 12'h010;
    localparam logic [11:0]   OFF_PERM    = 12'h04C;
    localparam logic [11:0]   OFF_PROG    = 12'h064;
    localparam logic [11:0]   OFF_SWRITE  = 12'h07C;
    localparam logic [11:0]   OFF_RELOAD  = 12'h094;
    localparam int            GBIT_UPPER  = 0;
    localparam int            GBIT_DEBUG  = 2;
    localparam int            GBIT_PROG   = 3;
    localparam logic [31:0]   GLOBAL_MASK = (32'd1 << GBIT_UPPER) |
                                            (32'd1 << GBIT_DEBUG) |
                                            (32'd1 << GBIT_PROG);
endpackage

// File: rtl/fwl_bitmap.sv
module fwl_bitmap
    import fuse_lock_pkg::*;
#(
    parameter int          NUM_BANKS = 3,
    parameter logic [11:0] BASE      = 12'h000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [BANK_BITS-1:0]          wr_data,
    output logic [NUM_BANKS*BANK_BITS-1:0] bits
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] BANK_ADDR = BASE + ADDR_W'(4 * b);
        logic [BANK_BITS-1:0] bank_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q <= '0;
            end else if (wr_en && (wr_addr == BANK_ADDR)) begin
                bank_q <= bank_q | wr_data;
            end
        end

        assign bits[b*BANK_BITS +: BANK_BITS] = bank_q;
    end
endmodule

// File: rtl/fwl_global.sv
module fwl_global
    import fuse_lock_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BANK_BITS-1:0] wr_data,
    output logic [BANK_BITS-1:0] glob
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob <= '0;
        end else if (wr_en && (wr_addr == OFF_GLOBAL)) begin
            glob <= glob | (wr_data & GLOBAL_MASK);
        end
    end
endmodule

// File: rtl/fwl_grant.sv
module fwl_grant
    import fuse_lock_pkg::*;
#(
    parameter int NUM_BANKS   = 3,
    parameter int UPPER_START = 32,
    localparam int WORDS      = NUM_BANKS * BANK_BITS,
    localparam int IDXW       = $clog2(WORDS) + 1
) (
    input  logic [WORDS-1:0]     reload_bits,
    input  logic [WORDS-1:0]     swrite_bits,
    input  logic [WORDS-1:0]     prog_bits,
    input  logic [WORDS-1:0]     perm_bits,
    input  logic [BANK_BITS-1:0] glob,
    input  logic [IDXW-1:0]      idx,
    output logic                 reload_ok,
    output logic                 swrite_ok,
    output logic                 prog_ok
);
    logic in_range;
    logic upper_deny;
    logic r_lk, w_lk, p_lk, perm_lk;

    always_comb begin
        in_range   = int'(idx) < WORDS;
        upper_deny = glob[GBIT_UPPER] && (int'(idx) >= UPPER_START);
        r_lk    = 1'b1;
        w_lk    = 1'b1;
        p_lk    = 1'b1;
        perm_lk = 1'b1;
        for (int i = 0; i < WORDS; i++) begin
            if (int'(idx) == i) begin
                r_lk    = reload_bits[i];
                w_lk    = swrite_bits[i];
                p_lk    = prog_bits[i];
                perm_lk = perm_bits[i];
            end
        end
        reload_ok = in_range && !upper_deny && !r_lk;
        swrite_ok = in_range && !upper_deny && !w_lk;
        prog_ok   = in_range && !upper_deny && !p_lk && !perm_lk
                    && !glob[GBIT_PROG];
    end
endmodule

// File: rtl/fuse_word_lock.sv
module fuse_word_lock
    import fuse_lock_pkg::*;
#(
    parameter int NUM_BANKS   = 3,
    parameter int UPPER_START = 32,
    localparam int WORDS      = NUM_BANKS * 32,
    localparam int IDXW       = $clog2(WORDS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [11:0]      reg_waddr,
    input  logic [31:0]      reg_wdata,
    input  logic [11:0]      reg_raddr,
    output logic [31:0]      reg_rdata,
    input  logic [WORDS-1:0] perm_locked_i,
    input  logic [IDXW-1:0]  chk_idx,
    output logic             reload_ok,
    output logic             swrite_ok,
    output logic             prog_ok,
    output logic             debug_cfg_locked
);
    logic [WORDS-1:0] reload_bits;
    logic [WORDS-1:0] swrite_bits;
    logic [WORDS-1:0] prog_bits;
    logic [31:0]      glob;

    fwl_bitmap #(.NUM_BANKS(NUM_BANKS), .BASE(OFF_RELOAD)) u_reload (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_addr(reg_waddr),
        .wr_data(reg_wdata), .bits(reload_bits)
    );

    fwl_bitmap #(.NUM_BANKS(NUM_BANKS), .BASE(OFF_SWRITE)) u_swrite (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_addr(reg_waddr),
        .wr_data(reg_wdata), .bits(swrite_bits)
    );

    fwl_bitmap #(.NUM_BANKS(NUM_BANKS), .BASE(OFF_PROG)) u_prog (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_addr(reg_waddr),
        .wr_data(reg_wdata), .bits(prog_bits)
    );

    fwl_global u_global (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_addr(reg_waddr),
        .wr_data(reg_wdata), .glob(glob)
    );

    fwl_grant #(.NUM_BANKS(NUM_BANKS), .UPPER_START(UPPER_START)) u_grant (
        .reload_bits(reload_bits), .swrite_bits(swrite_bits),
        .prog_bits(prog_bits), .perm_bits(perm_locked_i), .glob(glob),
        .idx(chk_idx), .reload_ok(reload_ok), .swrite_ok(swrite_ok),
        .prog_ok(prog_ok)
    );

    assign debug_cfg_locked = glob[GBIT_DEBUG];

    // Read mux: one offset per bank of each bitmap, plus the global word.
    always_comb begin
        reg_rdata = '0;
        if (reg_raddr == OFF_GLOBAL) begin
            reg_rdata = glob;
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_raddr == OFF_PERM + 12'(4 * b))
                reg_rdata = perm_locked_i[b*32 +: 32];
            if (reg_raddr == OFF_PROG + 12'(4 * b))
                reg_rdata = prog_bits[b*32 +: 32];
            if (reg_raddr == OFF_SWRITE + 12'(4 * b))
                reg_rdata = swrite_bits[b*32 +: 32];
            if (reg_raddr == OFF_RELOAD + 12'(4 * b))
                reg_rdata = reload_bits[b*32 +: 32];
        end
    end
endmodule

// File: rtl/fuse_word_lock_chk.sv
module fuse_word_lock_chk #(
    parameter int NUM_BANKS   = 3,
    parameter int UPPER_START = 32,
    localparam int WORDS      = NUM_BANKS * 32,
    localparam int IDXW       = $clog2(WORDS) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [11:0]      reg_raddr,
    input logic [31:0]      reg_rdata,
    input logic [WORDS-1:0] perm_locked_i,
    input logic [IDXW-1:0]  chk_idx,
    input logic             reload_ok,
    input logic             swrite_ok,
    input logic             prog_ok,
    input logic [WORDS-1:0] reload_bits,
    input logic [WORDS-1:0] swrite_bits,
    input logic [WORDS-1:0] prog_bits,
    input logic [31:0]      glob
);
    a_r3_bits_never_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(reload_bits) & ~reload_bits) == '0) &&
         (($past(swrite_bits) & ~swrite_bits) == '0) &&
         (($past(prog_bits) & ~prog_bits) == '0) &&
         (($past(glob) & ~glob) == '0)));

    a_r10_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ($stable(reload_bits) && $stable(swrite_bits) &&
                     $stable(prog_bits) && $stable(glob)));

    a_r6_global_prog_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        glob[3] |-> !prog_ok);

    a_r6_global_read_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_raddr == 12'h010) |-> (reg_rdata[31:4] == '0 && !reg_rdata[1]));

    a_r7_upper_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (glob[0] && int'(chk_idx) >= UPPER_START) |->
            (!reload_ok && !swrite_ok && !prog_ok));

    a_r8_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(chk_idx) >= WORDS) |-> (!reload_ok && !swrite_ok && !prog_ok));

    a_r5_perm_blocks_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(chk_idx) < WORDS && perm_locked_i[chk_idx[IDXW-2:0]] &&
         int'(chk_idx[IDXW-2:0]) == int'(chk_idx)) |-> !prog_ok);
endmodule

bind fuse_word_lock fuse_word_lock_chk #(
    .NUM_BANKS(NUM_BANKS), .UPPER_START(UPPER_START)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_raddr(reg_raddr),
    .reg_rdata(reg_rdata), .perm_locked_i(perm_locked_i), .chk_idx(chk_idx),
    .reload_ok(reload_ok), .swrite_ok(swrite_ok), .prog_ok(prog_ok),
    .reload_bits(reload_bits), .swrite_bits(swrite_bits),
    .prog_bits(prog_bits), .glob(glob)
);

// File: tb/fuse_word_lock_tb.sv
module fuse_word_lock_tb;
    localparam int NB    = 3;
    localparam int UPPER = 32;
    localparam int WORDS = NB * 32;
    localparam int IDXW  = $clog2(WORDS) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [11:0]      reg_waddr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [11:0]      reg_raddr = '0;
    logic [31:0]      reg_rdata;
    logic [WORDS-1:0] perm_locked_i = '0;
    logic [IDXW-1:0]  chk_idx = '0;
    logic             reload_ok, swrite_ok, prog_ok, debug_cfg_locked;

    logic [WORDS-1:0] m_rl = '0, m_sw = '0, m_pg = '0;
    logic [31:0]      m_gl = '0;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fuse_word_lock #(.NUM_BANKS(NB), .UPPER_START(UPPER)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .perm_locked_i(perm_locked_i), .chk_idx(chk_idx),
        .reload_ok(reload_ok), .swrite_ok(swrite_ok), .prog_ok(prog_ok),
        .debug_cfg_locked(debug_cfg_locked)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bench model of register writes (R2, R3, R6, R9, R10).
    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        for (int b = 0; b < NB; b++) begin
            if (a == 12'h064 + 12'(4*b)) m_pg[b*32 +: 32] |= d;
            if (a == 12'h07C + 12'(4*b)) m_sw[b*32 +: 32] |= d;
            if (a == 12'h094 + 12'(4*b)) m_rl[b*32 +: 32] |= d;
        end
        if (a == 12'h010) m_gl |= d & 32'h0000_000D;
    endtask

    function automatic logic [31:0] exp_rd(logic [11:0] a);
        logic [31:0] r = '0;
        if (a == 12'h010) r = m_gl;
        for (int b = 0; b < NB; b++) begin
            if (a == 12'h04C + 12'(4*b)) r = perm_locked_i[b*32 +: 32];
            if (a == 12'h064 + 12'(4*b)) r = m_pg[b*32 +: 32];
            if (a == 12'h07C + 12'(4*b)) r = m_sw[b*32 +: 32];
            if (a == 12'h094 + 12'(4*b)) r = m_rl[b*32 +: 32];
        end
        return r;
    endfunction

    task automatic check_regs(string req);
        for (int a = 0; a <= 'hB0; a += 4) begin
            reg_raddr = 12'(a);
            #1;
            check(req, reg_rdata, exp_rd(12'(a)));
        end
        check({req, " R6 debug"}, {31'd0, debug_cfg_locked}, {31'd0, m_gl[2]});
    endtask

    // Sweep of every representable index (R4, R5, R6, R7, R8).
    task automatic sweep(string req);
        for (int i = 0; i < (1 << IDXW); i++) begin
            logic inr, up, er, ew, ep;
            chk_idx = IDXW'(i);
            #1;
            inr = i < WORDS;
            up  = m_gl[0] && i >= UPPER;
            er  = inr && !up && !m_rl[inr ? i : 0];
            ew  = inr && !up && !m_sw[inr ? i : 0];
            ep  = inr && !up && !m_pg[inr ? i : 0] && !m_gl[3]
                  && !perm_locked_i[inr ? i : 0];
            check(req, {29'd0, reload_ok, swrite_ok, prog_ok}, {29'd0, er, ew, ep});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_regs("R1 reset regs");
        sweep("R1 reset grants");

        // R2, R4: distinct patterns per bitmap and bank
        wr(12'h064, 32'h8000_0001);
        wr(12'h068, 32'h0000_F000);
        wr(12'h06C, 32'h8000_0000);
        wr(12'h07C, 32'h0000_0002);
        wr(12'h080, 32'h00FF_0000);
        wr(12'h098, 32'h0000_0010);
        wr(12'h09C, 32'h0000_0001);
        check_regs("R2 set bits");
        sweep("R4 per-word grants");

        // R3: zeros and overlaps do not clear
        wr(12'h064, 32'h0000_0000);
        wr(12'h080, 32'h0F0F_0000);
        wr(12'h098, 32'h0000_0000);
        check_regs("R3 no clear");
        sweep("R3 grants after zero writes");

        // R5, R9: permanent lock view, writes to it ignored
        perm_locked_i = {32'hA5A5_0000, 32'h0000_0100, 32'h0000_0004};
        wr(12'h04C, 32'hFFFF_FFFF);
        wr(12'h050, 32'hFFFF_FFFF);
        check_regs("R9 perm view");
        sweep("R5 perm blocks program");

        // R10: unmapped offsets
        wr(12'h070, 32'hFFFF_FFFF);
        wr(12'h0A0, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        check_regs("R10 unmapped");

        // R6: masked bits, debug lock
        wr(12'h010, 32'hFFFF_FFF2);
        check_regs("R6 masked bits");
        wr(12'h010, 32'h0000_0004);
        check_regs("R6 debug lock");
        // R7: upper area lock
        wr(12'h010, 32'h0000_0001);
        check_regs("R7 upper lock regs");
        sweep("R7 upper area");
        wr(12'h010, 32'h0000_0000);
        check_regs("R3 global sticky");
        // R6: program-all lock
        wr(12'h010, 32'h0000_0008);
        sweep("R6 program all");
        check_regs("R6 final regs");
        chk_idx = IDXW'(WORDS + 5);
        #1;
        check("R8 out of range", {29'd0, reload_ok, swrite_ok, prog_ok}, 32'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule